// File: doc/BRIEF.md
# Card configuration reset sequencer

This block performs a timed soft reset of a removable card by working on the card's byte-wide configuration option register through a simple byte read/write master port. Software or a higher-level controller gives the register's base address and one of two commands. The block then runs the whole sequence by itself. It reports that it is busy, and it pulses a done strobe when the sequence is over.

A plain reset reads the configuration byte once and keeps it. It writes the byte back with the soft-reset bit set, holds for a short wait, and writes the byte back with the soft-reset bit cleared. A short wait follows the release before the block finishes. An extended reset uses longer waits. While reset is held, it also writes a caller-supplied host-control byte to the register address plus two. In both variants every bit other than the soft-reset bit is written back exactly as it was read. Wait lengths are given in milliseconds and converted to clock cycles from a clock-frequency parameter. A divider parameter shortens them for simulation.

Top module: `cor_reset_seq`

## Requirements
- R1: A synchronous active-high `rst` returns the block to idle within one clock, even in the middle of a sequence. After that clock, `busy`, `done`, `busRdEn` and `busWrEn` are all low, and no further bus writes occur.
- R2: A command sampled while idle makes `busy` high from the next cycle. `corBase` and `hostCtl` are taken at that same edge. The first bus action is exactly one read at the taken base address.
- R3: Read data is expected one cycle after `busRdEn`, marked by `busRdValid`. The byte presented with `busRdValid` is the value kept for the writes that follow.
- R4: A plain reset writes (kept byte OR 0x80) to the base address. After the short wait it writes the kept byte with bit 7 cleared to the base address, and then performs a final short wait.
- R5: Bits 6..0 of both base-address writes equal bits 6..0 of the kept byte, including the level-interrupt bit 6 and the function-enable bit 0. After the sequence the register holds the kept byte with bit 7 cleared.
- R6: An extended reset uses the long wait for all three of its waits. Between the assert write and the release write it writes `hostCtl` to base address + 2. A plain reset never touches base + 2.
- R7: A wait lasts N = MS × CLK_HZ / 1000 / TIME_DIV cycles, where MS is 2 for short and 10 for long. Consecutive writes of a sequence are N + 1 cycles apart.
- R8: `done` is high for exactly one cycle, which is the last cycle of the final wait, N cycles after the release write. `busy` is low in the following cycle.
- R9: A command that arrives while `busy` is high is ignored. It causes no extra read and no extra write, and it does not change the address or host byte in use.
- R10: When both commands are high in the same idle cycle, the extended reset is performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmdPlain | input | 1 | Start a plain reset (sampled while idle) |
| cmdExt | input | 1 | Start an extended reset (sampled while idle) |
| corBase | input | ADDR_W | Byte address of the configuration register |
| hostCtl | input | 8 | Host-control byte for the extended reset |
| busAddr | output | ADDR_W | Master port byte address |
| busRdEn | output | 1 | Read strobe, one cycle |
| busRdData | input | 8 | Read data |
| busRdValid | input | 1 | Read data valid, one cycle after the read strobe |
| busWrEn | output | 1 | Write strobe, one cycle |
| busWrData | output | 8 | Write data |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse at the end of a sequence |

## Verification
The embedded assertions check several rules on every cycle. Read and write strobes are never high together, and no two writes fall in back-to-back cycles. Each sequence opens with a read. The preserved bits of every register write match the kept byte. The cycle after done is always idle, and busy is low on the first cycle after reset. The bench scenarios cover what a single cycle cannot show. These are the exact cycle distances between writes and to done, the host-byte write landing at base + 2, the final register contents, and ignored commands leaving no trace on the bus. They also cover a reset in mid-sequence followed by a long quiet period.

// File: rtl/cor_seq_pkg.sv
package cor_seq_pkg;

  // Soft-reset bit of the configuration byte
  localparam logic [7:0] COR_SRST = 8'h80;

  typedef enum logic [1:0] {
    WD_SET  = 2'd0,
    WD_HOST = 2'd1,
    WD_CLR  = 2'd2
  } wrSel_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic   accept;    // take base address and host byte
    logic   rdStb;     // issue the read
    logic   capture;   // keep the returned byte
    logic   wrStb;     // issue a write
    wrSel_e wrSel;     // which write
    logic   loadTmr;   // start a wait
    logic   longWait;  // long rather than short wait
    logic   tick;      // count the wait down
  } ctlStrb_t;

endpackage

// File: rtl/cor_seq_dp.sv
module cor_seq_dp
  import cor_seq_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int CNT_W     = 8,
  parameter int SHORT_CYC = 4,
  parameter int LONG_CYC  = 20,
  parameter int HOST_OFS  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  ctlStrb_t          strb,
  input  logic [ADDR_W-1:0] corBase,
  input  logic [7:0]        hostCtl,
  input  logic [7:0]        busRdData,
  output logic [ADDR_W-1:0] busAddr,
  output logic [7:0]        busWrData,
  output logic              tmrZero
);

  logic [ADDR_W-1:0] baseQ;
  logic [7:0]        hostQ;
  logic [7:0]        savedQ;
  logic [CNT_W-1:0]  cntQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      baseQ  <= '0;
      hostQ  <= '0;
      savedQ <= '0;
    end else begin
      if (strb.accept) begin
        baseQ <= corBase;
        hostQ <= hostCtl;
      end
      if (strb.capture) savedQ <= busRdData;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                        cntQ <= '0;
    else if (strb.loadTmr)          cntQ <= strb.longWait ? CNT_W'(LONG_CYC - 1)
                                                          : CNT_W'(SHORT_CYC - 1);
    else if (strb.tick && !tmrZero) cntQ <= cntQ - 1'b1;
  end

  assign tmrZero = (cntQ == '0);

  always_comb begin
    busAddr   = baseQ;
    busWrData = savedQ;
    case (strb.wrSel)
      WD_SET:  busWrData = savedQ | COR_SRST;
      WD_HOST: begin
        busAddr   = baseQ + ADDR_W'(HOST_OFS);
        busWrData = hostQ;
      end
      default: busWrData = savedQ & ~COR_SRST;
    endcase
  end

  // R5
  keep_bits_chk: assert property (@(posedge clk) disable iff (rst)
    (strb.wrStb && strb.wrSel != WD_HOST) |-> (busWrData[6:0] == savedQ[6:0]));

endmodule

// File: rtl/cor_seq_ctrl.sv
module cor_seq_ctrl
  import cor_seq_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     cmdPlain,
  input  logic     cmdExt,
  input  logic     busRdValid,
  input  logic     tmrZero,
  output ctlStrb_t strb,
  output logic     busy,
  output logic     done
);

  typedef enum logic [3:0] {
    S_IDLE, S_RD, S_RDW, S_WSET, S_T1, S_WHOST, S_T2, S_WCLR, S_T3
  } state_e;

  state_e stateQ, stateD;
  logic   extQ, extD;

  always_ff @(posedge clk) begin
    if (rst) begin
      stateQ <= S_IDLE;
      extQ   <= 1'b0;
    end else begin
      stateQ <= stateD;
      extQ   <= extD;
    end
  end

  always_comb begin
    stateD = stateQ;
    extD   = extQ;
    strb   = '0;
    strb.wrSel = WD_CLR;
    done   = 1'b0;
    case (stateQ)
      S_IDLE: if (cmdPlain || cmdExt) begin
        strb.accept = 1'b1;
        extD   = cmdExt;
        stateD = S_RD;
      end
      S_RD: begin
        strb.rdStb = 1'b1;
        stateD = S_RDW;
      end
      S_RDW: if (busRdValid) begin
        strb.capture = 1'b1;
        stateD = S_WSET;
      end
      S_WSET: begin
        strb.wrStb    = 1'b1;
        strb.wrSel    = WD_SET;
        strb.loadTmr  = 1'b1;
        strb.longWait = extQ;
        stateD = S_T1;
      end
      S_T1: begin
        strb.tick = 1'b1;
        if (tmrZero) stateD = extQ ? S_WHOST : S_WCLR;
      end
      S_WHOST: begin
        strb.wrStb    = 1'b1;
        strb.wrSel    = WD_HOST;
        strb.loadTmr  = 1'b1;
        strb.longWait = 1'b1;
        stateD = S_T2;
      end
      S_T2: begin
        strb.tick = 1'b1;
        if (tmrZero) stateD = S_WCLR;
      end
      S_WCLR: begin
        strb.wrStb    = 1'b1;
        strb.wrSel    = WD_CLR;
        strb.loadTmr  = 1'b1;
        strb.longWait = extQ;
        stateD = S_T3;
      end
      S_T3: begin
        strb.tick = 1'b1;
        if (tmrZero) begin
          done   = 1'b1;
          stateD = S_IDLE;
        end
      end
      default: stateD = S_IDLE;
    endcase
  end

  assign busy = (stateQ != S_IDLE);

  // R3
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(strb.rdStb && strb.wrStb));

  // R7
  wr_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    strb.wrStb |=> !strb.wrStb);

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !busy);

  // R2
  read_first_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> strb.rdStb);

  // R1
  reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!busy && !done));

endmodule

// File: rtl/cor_reset_seq.sv
module cor_reset_seq
  import cor_seq_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int CLK_HZ   = 50_000_000,
  parameter int TIME_DIV = 1,
  parameter int SHORT_MS = 2,
  parameter int LONG_MS  = 10,
  parameter int HOST_OFS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmdPlain,
  input  logic              cmdExt,
  input  logic [ADDR_W-1:0] corBase,
  input  logic [7:0]        hostCtl,
  output logic [ADDR_W-1:0] busAddr,
  output logic              busRdEn,
  input  logic [7:0]        busRdData,
  input  logic              busRdValid,
  output logic              busWrEn,
  output logic [7:0]        busWrData,
  output logic              busy,
  output logic              done
);

  localparam int CYC_PER_MS = CLK_HZ / 1000 / TIME_DIV;
  localparam int SHORT_CYC  = SHORT_MS * CYC_PER_MS;
  localparam int LONG_CYC   = LONG_MS * CYC_PER_MS;
  localparam int CNT_W      = $clog2(LONG_CYC + 1);

  initial begin
    param_chk: assert (SHORT_CYC >= 1 && LONG_CYC >= SHORT_CYC);
  end

  ctlStrb_t strb;
  logic     tmrZero;

  cor_seq_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .cmdPlain   (cmdPlain),
    .cmdExt     (cmdExt),
    .busRdValid (busRdValid),
    .tmrZero    (tmrZero),
    .strb       (strb),
    .busy       (busy),
    .done       (done)
  );

  cor_seq_dp #(
    .ADDR_W    (ADDR_W),
    .CNT_W     (CNT_W),
    .SHORT_CYC (SHORT_CYC),
    .LONG_CYC  (LONG_CYC),
    .HOST_OFS  (HOST_OFS)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .strb      (strb),
    .corBase   (corBase),
    .hostCtl   (hostCtl),
    .busRdData (busRdData),
    .busAddr   (busAddr),
    .busWrData (busWrData),
    .tmrZero   (tmrZero)
  );

  assign busRdEn = strb.rdStb;
  assign busWrEn = strb.wrStb;

endmodule

// File: tb/test_cor_reset_seq.sv
module test_cor_reset_seq;

  localparam int AW  = 16;
  localparam int SW  = 40;   // 2 ms at 20 cycles/ms
  localparam int LW  = 200;  // 10 ms at 20 cycles/ms

  // {ext, init, host, base}
  localparam logic [24:0] VECS [0:5] = '{
    {1'b0, 8'h41, 8'h00, 8'h10},
    {1'b0, 8'hC1, 8'h00, 8'h20},
    {1'b1, 8'h45, 8'h0F, 8'h30},
    {1'b1, 8'h00, 8'hFF, 8'h40},
    {1'b0, 8'h7F, 8'h00, 8'h50},
    {1'b1, 8'hFF, 8'h81, 8'h60}
  };

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst = 1'b1;
  logic          cmdPlain = 1'b0, cmdExt = 1'b0;
  logic [AW-1:0] corBase = '0;
  logic [7:0]    hostCtl = '0;
  logic [AW-1:0] busAddr;
  logic          busRdEn, busWrEn, busy, done;
  logic [7:0]    busRdData = '0, busWrData;
  logic          busRdValid = 1'b0;

  cor_reset_seq #(.ADDR_W(AW), .CLK_HZ(50_000_000), .TIME_DIV(2500)) i_cor_reset_seq (
    .clk(clk), .rst(rst), .cmdPlain(cmdPlain), .cmdExt(cmdExt),
    .corBase(corBase), .hostCtl(hostCtl), .busAddr(busAddr),
    .busRdEn(busRdEn), .busRdData(busRdData), .busRdValid(busRdValid),
    .busWrEn(busWrEn), .busWrData(busWrData), .busy(busy), .done(done)
  );

  // Bus slave model and logs
  logic [7:0]  mem [0:255];
  logic        preEn = 1'b0;
  logic [7:0]  preAddr = '0, preData = '0;
  logic [15:0] wA [0:127];
  logic [7:0]  wD [0:127];
  int          wC [0:127];
  int cyc = 0, wrCount = 0, rdCount = 0, doneCount = 0, doneCyc = 0;

  always @(posedge clk) begin
    cyc        <= cyc + 1;
    busRdValid <= busRdEn;
    busRdData  <= mem[busAddr[7:0]];
    if (preEn) mem[preAddr] <= preData;
    if (busRdEn) rdCount <= rdCount + 1;
    if (busWrEn) begin
      mem[busAddr[7:0]] <= busWrData;
      wA[wrCount % 128] <= busAddr;
      wD[wrCount % 128] <= busWrData;
      wC[wrCount % 128] <= cyc;
      wrCount <= wrCount + 1;
    end
    if (done) begin
      doneCount <= doneCount + 1;
      doneCyc   <= cyc;
    end
  end

  int total = 0, bad = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic preload(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    preEn = 1'b1; preAddr = a; preData = d;
    @(negedge clk);
    preEn = 1'b0;
  endtask

  task automatic runSeq(input bit ext, input bit plain, input logic [7:0] init,
                        input logic [7:0] hcr, input logic [7:0] base);
    int w0, d0, r0, n, w, last;
    preload(base, init);
    preload(base + 8'd2, 8'h5A);
    w0 = wrCount; d0 = doneCount; r0 = rdCount;
    n = ext ? 3 : 2;
    w = ext ? LW : SW;
    @(negedge clk);
    cmdExt = ext; cmdPlain = plain; hostCtl = hcr; corBase = AW'(base);
    @(negedge clk);
    cmdExt = 1'b0; cmdPlain = 1'b0; corBase = 16'h00F0; hostCtl = 8'hEE;
    chk(busy == 1'b1, "R2 busy", int'(busy), 1);
    while (busy) @(negedge clk);
    chk(rdCount - r0 == 1, "R2 reads", rdCount - r0, 1);
    chk(wrCount - w0 == n, "R4 R6 R10 writes", wrCount - w0, n);
    chk(wA[w0] == 16'(base), "R4 set addr", int'(wA[w0]), int'(base));
    chk(wD[w0] == (init | 8'h80), "R3 R4 set data", int'(wD[w0]), int'(init | 8'h80));
    if (ext) begin
      chk(wA[w0+1] == 16'(base) + 16'd2, "R6 host addr", int'(wA[w0+1]), int'(base) + 2);
      chk(wD[w0+1] == hcr, "R6 host data", int'(wD[w0+1]), int'(hcr));
    end
    last = w0 + n - 1;
    chk(wA[last] == 16'(base), "R4 clr addr", int'(wA[last]), int'(base));
    chk(wD[last] == (init & 8'h7F), "R5 clr data", int'(wD[last]), int'(init & 8'h7F));
    for (int k = w0 + 1; k <= last; k++)
      chk(wC[k] - wC[k-1] == w + 1, "R7 gap", wC[k] - wC[k-1], w + 1);
    chk(doneCount - d0 == 1, "R8 done pulses", doneCount - d0, 1);
    chk(doneCyc - wC[last] == w, "R8 done time", doneCyc - wC[last], w);
    chk(mem[base] == (init & 8'h7F), "R5 final", int'(mem[base]), int'(init & 8'h7F));
    chk(mem[base + 8'd2] == (ext ? hcr : 8'h5A), "R6 offset byte",
        int'(mem[base + 8'd2]), int'(ext ? hcr : 8'h5A));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL R8 watchdog act=timeout exp=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int w0, d0, r0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !done && !busRdEn && !busWrEn, "R1 reset state",
        {busy, done, busRdEn, busWrEn}, 0);
    rst = 1'b0;

    for (int i = 0; i < 6; i++)
      runSeq(VECS[i][24], !VECS[i][24], VECS[i][23:16], VECS[i][15:8], VECS[i][7:0]);

    // R10 both commands at once
    runSeq(1'b1, 1'b1, 8'h43, 8'h3C, 8'hA0);

    // R9 command during busy is ignored
    preload(8'h70, 8'h03);
    preload(8'h72, 8'h5A);
    preload(8'h82, 8'h5A);
    w0 = wrCount; d0 = doneCount; r0 = rdCount;
    @(negedge clk); cmdPlain = 1'b1; corBase = 16'h0070;
    @(negedge clk); cmdPlain = 1'b0;
    repeat (10) @(negedge clk);
    cmdExt = 1'b1; corBase = 16'h0080; hostCtl = 8'h99;
    @(negedge clk); cmdExt = 1'b0;
    while (busy) @(negedge clk);
    chk(wrCount - w0 == 2, "R9 writes", wrCount - w0, 2);
    chk(rdCount - r0 == 1, "R9 reads", rdCount - r0, 1);
    chk(mem[8'h72] == 8'h5A && mem[8'h82] == 8'h5A, "R9 untouched",
        int'(mem[8'h82]), 8'h5A);
    chk(mem[8'h70] == 8'h03, "R9 base kept", int'(mem[8'h70]), 8'h03);
    chk(doneCount - d0 == 1, "R9 done", doneCount - d0, 1);

    // R1 reset in mid-sequence
    preload(8'h90, 8'h41);
    w0 = wrCount; d0 = doneCount;
    @(negedge clk); cmdExt = 1'b1; corBase = 16'h0090; hostCtl = 8'h11;
    @(negedge clk); cmdExt = 1'b0;
    repeat (50) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(!busy && !done && !busRdEn && !busWrEn, "R1 abort state",
        {busy, done, busRdEn, busWrEn}, 0);
    repeat (3 * LW) @(negedge clk);
    chk(wrCount - w0 == 1, "R1 no writes after abort", wrCount - w0, 1);
    chk(doneCount == d0, "R1 no done after abort", doneCount - d0, 0);
    chk(mem[8'h90] == 8'hC1, "R1 left asserted", int'(mem[8'h90]), 8'hC1);

    // Fresh plain reset after abort
    runSeq(1'b0, 1'b1, 8'hC1, 8'h00, 8'h90);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule